// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block collects 256 interrupt lines into a three-level tree and drives one summary interrupt. The lines form 32 groups of 8, and each set of 8 groups reports to one of 4 upper-level collectors. Software finds the source by walking down the tree: it reads the root byte, then the collector byte it flags, then the latched byte of the group it flags.

All access runs through a byte-wide register port with a 16-bit address. A nine-byte window starts at `0x01BB`. A group is picked by writing a select byte. After that, the group's latched status and its live line levels can be read, and a configuration byte can be written to any one of its lines. That byte carries the line index and a commit bit. It sets edge or level detection, a mask for each polarity, and a clear action.

Top module: `irq_tree_ctrl`

## Requirements
- R1: The window holds these byte offsets from `0x01BB`: +0 root, +1 to +4 collectors 0 to 3, +5 group select, +6 latched group status, +7 line configuration, +8 live line levels. Read data appears on `bus_rdata` in the cycle after the strobe. It is 0 in any cycle that follows no read.
- R2: After reset, every line is in edge mode with both masks set, all latched bits are 0, the select is 0 and `irq_out` is low.
- R3: A write at +5 loads its low 5 bits into the group select. A read at +5 returns the select.
- R4: A read at +8 returns the present levels of the selected group's 8 lines. Bit b is line select×8+b.
- R5: A write at +7 is applied only when bit 7 is 1. Bits 6:4 name the line within the selected group. Bit 0 set means level mode. Bit 1 masks the falling edge (the low level in level mode). Bit 2 masks the rising edge (the high level in level mode).
- R6: In edge mode, an unmasked transition sets the line's latched bit. The bit stays set until a committed write at +7 with bit 3 set clears it, even if the line changes again.
- R7: In level mode, the latched bit follows the unmasked active level, one cycle behind the line. Bit 3 then has no lasting effect while that level persists.
- R8: Collector m, bit b, is 1 when group m×8+b has a latched bit on a line that has at least one mask clear.
- R9: Root bit m+1 is 1 when collector m is nonzero. Bit 0 is the OR of bits 4:1, and bits 7:5 read 0. `irq_out` equals root bit 0.
- R10: Writing both masks together with bit 3 acknowledges and silences the line. Rewriting the mode with the masks clear re-enables the line and does not raise the old event again.
- R11: Reads of offset +7 and of addresses outside the window return 0. Writes outside the window change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 256 | Interrupt inputs, synchronous to clk |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| irq_out | output | 1 | Summary interrupt |

## Verification
A line change presented before clock edge k is latched at edge k. From that point both `irq_out` and the status bytes reflect it. A read strobed at edge k+1 returns its byte after edge k+1. A configuration or select write lands at its own edge, so a read strobed in the next cycle already sees it. The bench drives on falling edges. It leaves at least one full cycle between a stimulus and the read that observes it. The monitor compares `bus_rdata` 3 ns after the rising edge that follows each read strobe.

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl #(
  parameter int          NUM_LINES  = 256,
  parameter logic [15:0] BASE_ADDR  = 16'h01BB,
  parameter logic [15:0] ADDR_LIMIT = 16'h03FF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [15:0]          bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 irq_out
);
  localparam int NBLK = NUM_LINES / 8;
  localparam int NMST = (NBLK + 7) / 8;
  localparam int SELW = $clog2(NBLK);
  localparam int IDXW = SELW + 3;

  logic [NUM_LINES-1:0] lvl_mode, msk_fe, msk_re, stat, prev;
  logic [SELW-1:0]      sel;
  logic [NBLK-1:0]      blk_any;
  logic [NMST*8-1:0]    blk_pad;
  logic [NMST-1:0]      mst_any;
  logic [7:0]           root_v, rd_n;

  wire [NUM_LINES-1:0] pend  = stat & ~(msk_fe & msk_re);
  wire [15:0]          off   = bus_addr - BASE_ADDR;
  wire                 hit   = (bus_addr >= BASE_ADDR) && (bus_addr <= BASE_ADDR + 16'd8)
                               && (bus_addr <= ADDR_LIMIT);
  wire                 wr_en = bus_valid && bus_write && hit;
  wire                 sel_wr = wr_en && (off == 16'd5);
  wire                 cfg_wr = wr_en && (off == 16'd7) && bus_wdata[7];
  wire [IDXW-1:0]      cfg_idx = {sel, bus_wdata[6:4]};

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    assign blk_any[b] = |pend[b*8 +: 8];
  end
  assign blk_pad = (NMST*8)'(blk_any);
  for (genvar m = 0; m < NMST; m++) begin : g_mst
    assign mst_any[m] = |blk_pad[m*8 +: 8];
  end
  assign root_v  = 8'({mst_any, |mst_any});
  assign irq_out = |mst_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_mode <= '0;
      msk_fe   <= '1;
      msk_re   <= '1;
      stat     <= '0;
      prev     <= '0;
      sel      <= '0;
    end else begin
      prev <= irq_lines;
      if (sel_wr) sel <= bus_wdata[SELW-1:0];
      for (int i = 0; i < NUM_LINES; i++) begin
        if (lvl_mode[i])
          stat[i] <= (irq_lines[i] & ~msk_re[i]) | (~irq_lines[i] & ~msk_fe[i]);
        else
          stat[i] <= (stat[i] & ~(cfg_wr && (cfg_idx == IDXW'(i)) && bus_wdata[3]))
                   | (irq_lines[i] & ~prev[i] & ~msk_re[i])
                   | (~irq_lines[i] & prev[i] & ~msk_fe[i]);
        if (cfg_wr && (cfg_idx == IDXW'(i))) begin
          lvl_mode[i] <= bus_wdata[0];
          msk_fe[i]   <= bus_wdata[1];
          msk_re[i]   <= bus_wdata[2];
        end
      end
    end
  end

  always_comb begin
    rd_n = 8'h00;
    if (hit) begin
      case (off[3:0])
        4'd0: rd_n = root_v;
        4'd5: rd_n = 8'(sel);
        4'd6: rd_n = stat[{sel, 3'b000} +: 8];
        4'd8: rd_n = irq_lines[{sel, 3'b000} +: 8];
        default: rd_n = 8'h00;
      endcase
      for (int m = 0; m < NMST; m++)
        if (off == 16'(m + 1)) rd_n = blk_pad[m*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= 8'h00;
    else        bus_rdata <= (bus_valid && !bus_write) ? rd_n : 8'h00;
  end
endmodule

// File: rtl/irq_tree_ctrl_chk.sv
module irq_tree_ctrl_chk #(
  parameter int          NUM_LINES = 256,
  parameter logic [15:0] BASE_ADDR = 16'h01BB
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [15:0]          bus_addr,
  input logic [7:0]           bus_wdata,
  input logic [7:0]           bus_rdata,
  input logic                 irq_out,
  input logic [4:0]           sel,
  input logic [NUM_LINES-1:0] lvl_mode,
  input logic [NUM_LINES-1:0] msk_fe,
  input logic [NUM_LINES-1:0] msk_re
);
  wire rd  = bus_valid && !bus_write;
  wire wr  = bus_valid && bus_write;
  wire out = (bus_addr < BASE_ADDR) || (bus_addr > BASE_ADDR + 16'd8);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> bus_rdata == 8'h00);
  p_sel_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == BASE_ADDR + 16'd5 |=> sel == $past(bus_wdata[4:0]));
  p_live_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == BASE_ADDR + 16'd8 |=> bus_rdata == $past(irq_lines[{sel, 3'b000} +: 8]));
  p_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_addr == BASE_ADDR + 16'd7 && !bus_wdata[7]
    |=> $stable(lvl_mode) && $stable(msk_fe) && $stable(msk_re));
  p_root_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd && bus_addr == BASE_ADDR |=> bus_rdata[0] == $past(irq_out) && bus_rdata[7:5] == 3'b000);
  p_outside_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd && out |=> bus_rdata == 8'h00);
  p_outside_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr && out |=> $stable(sel) && $stable(lvl_mode) && $stable(msk_fe) && $stable(msk_re));
endmodule

bind irq_tree_ctrl irq_tree_ctrl_chk #(.NUM_LINES(NUM_LINES), .BASE_ADDR(BASE_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .sel(sel), .lvl_mode(lvl_mode),
  .msk_fe(msk_fe), .msk_re(msk_re));

// File: tb/irq_tree_ctrl_tb_top.sv
module irq_tree_ctrl_tb_top;
  localparam logic [15:0] B = 16'h01BB;
  logic clk = 0, rst_n = 0;
  logic [255:0] irq_lines = '0;
  logic bus_valid = 0, bus_write = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_out;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  irq_tree_ctrl dut_i (.clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always begin
    @(posedge clk);
    if (bus_valid && !bus_write && rst_n) begin
      #3;
      checks++;
      if (exp_q.size() == 0) begin
        fails++; $display("FAIL scoreboard empty: act=%02h exp=none", bus_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++; $display("FAIL %s: act=%02h exp=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic acc(input bit w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask
  task automatic wr(input logic [15:0] a, input logic [7:0] d); acc(1, a, d); endtask
  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t); acc(0, a, 8'h00);
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask
  task automatic line(input int n, input logic v);
    @(negedge clk); irq_lines[n] = v; idle(1);
  endtask
  task automatic chk_irq(input logic e, input string t);
    @(negedge clk); checks++;
    if (irq_out !== e) begin fails++; $display("FAIL %s: act=%0b exp=%0b", t, irq_out, e); end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++; $display("FAIL watchdog: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    chk_irq(0, "R2 irq after reset");
    rd(B, 8'h00, "R2 root after reset");
    rd(B + 6, 8'h00, "R2 status after reset");
    rd(B + 5, 8'h00, "R2 select after reset");
    line(3, 1); line(3, 0);
    rd(B + 1, 8'h00, "R2 masked by default");
    wr(B + 5, 8'h23); rd(B + 5, 8'h03, "R3 select low bits");
    irq_lines[31:24] = 8'hA5; idle(1);
    rd(B + 8, 8'hA5, "R4 live levels group 3");
    irq_lines[31:24] = 8'h00; idle(1);
    wr(B + 7, 8'h10); line(25, 1); line(25, 0);
    rd(B + 6, 8'h00, "R5 uncommitted write ignored");
    chk_irq(0, "R5 irq stays low");
    wr(B + 7, 8'h90); line(25, 1);
    rd(B + 6, 8'h02, "R6 rising latched");
    chk_irq(1, "R9 irq high");
    rd(B + 1, 8'h08, "R8 collector 0 group 3");
    rd(B, 8'h03, "R9 root collector 0");
    line(25, 0);
    rd(B + 6, 8'h02, "R6 stays latched");
    wr(B + 7, 8'h9E);
    rd(B + 6, 8'h00, "R10 acknowledge clears");
    chk_irq(0, "R10 irq low after ack");
    wr(B + 7, 8'h90);
    rd(B + 6, 8'h00, "R10 unmask no re-raise");
    wr(B + 5, 8'd13); wr(B + 7, 8'hE2);
    line(110, 1);
    rd(B + 6, 8'h40, "R6 rising only latched");
    rd(B + 2, 8'h20, "R8 collector 1 group 13");
    rd(B, 8'h05, "R9 root collector 1");
    wr(B + 7, 8'hEA); line(110, 0);
    rd(B + 6, 8'h00, "R6 masked falling ignored");
    line(110, 1);
    rd(B + 6, 8'h40, "R6 second rise");
    wr(B + 7, 8'hEA);
    rd(B + 6, 8'h00, "R6 cleared");
    wr(B + 5, 8'd31); wr(B + 7, 8'hF3);
    rd(B + 6, 8'h00, "R7 level high inactive");
    line(255, 1);
    rd(B + 6, 8'h80, "R7 level high active");
    rd(B + 4, 8'h80, "R8 collector 3 group 31");
    rd(B, 8'h11, "R9 root collector 3");
    wr(B + 7, 8'hFB);
    rd(B + 6, 8'h80, "R7 clear no lasting effect");
    line(255, 0);
    rd(B + 6, 8'h00, "R7 level drops");
    chk_irq(0, "R7 irq follows level");
    wr(B + 7, 8'hF5); idle(1);
    rd(B + 6, 8'h80, "R7 active low");
    wr(B + 7, 8'hF7); idle(1);
    rd(B + 6, 8'h00, "R10 fully masked level");
    rd(B - 1, 8'h00, "R11 below window");
    rd(B + 9, 8'h00, "R11 above window");
    rd(B + 7, 8'h00, "R11 config reads zero");
    wr(B - 1, 8'h05); wr(B + 9, 8'h05);
    rd(B + 5, 8'h1F, "R11 outside writes ignored");
    rd(B + 8, 8'h00, "R1 live read offset");
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; fails++; $display("FAIL R1 pending reads: act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule